// File: doc/BRIEF.md
# Sub-window access forwarder

This block sits between a memory-mapped slave bus and one sub-block that owns a power-of-two address window. The address decoder upstream has already decided that the access falls inside the window and hands over a select. The forwarder turns the host byte address into a word offset inside the window. It gates the host read and write strobes with that select and passes write data down. The sub-block's read data, done and error flags go back to the host combinationally, so no cycle is added on either path.

The block is built at elaboration time for one window. A parameter picks shared addressing, where one select and one address serve both directions, or split addressing, where reads and writes have their own address bus and select. A second parameter makes the window read-only, write-only or read-write. A third turns error reporting on or off. The data path toward the sub-block is as wide as the narrower of the sub-block and the bus word. Narrower read data is zero-extended on the way back.

Top module: `subwin_fwd`

## Requirements
- R1: Each sub-block address output equals host address bits from log2(WORD_BYTES) up to log2(WIN_BYTES)-1 of its source address bus. It is a word offset of log2(WIN_BYTES)-log2(WORD_BYTES) bits.
- R2: The sub-block read strobe is high exactly when the read-side select and the host read strobe are both high.
- R3: The sub-block write strobe is high exactly when the write-side select and the host write strobe are both high.
- R4: Sub-block write data equals the low min(SUB_DATA_W, 8*WORD_BYTES) bits of the host write data.
- R5: With SPLIT=1 the write side takes its select and address from the write-side inputs. With SPLIT=0 the read-side select and address serve both directions, and the write-side select and address inputs have no effect on any output.
- R6: Host read data equals the sub-block read data, zero-extended to the bus word, while the read-side select is high. It is all zeros otherwise.
- R7: Each host done flag equals the matching sub-block done flag while that direction's select is high, in the same cycle. It is 0 otherwise.
- R8: With ERR_EN=1 each host error flag equals the matching sub-block error flag while that direction's select is high. With ERR_EN=0 both host error flags stay 0 whatever the sub-block drives.
- R9: In a read-only window, every write-direction output stays 0: select, address, data, strobe, done and error. In a write-only window the same holds for the read direction, including the read data.
- R10: With all host selects and strobes low, every strobe, select, done and error output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_addr_i | input | HOST_ADDR_W | Host byte address for reads; serves both directions when SPLIT=0 |
| wr_addr_i | input | HOST_ADDR_W | Host byte address for writes (SPLIT=1 only) |
| rd_sel_i | input | 1 | Decoded window hit for reads; serves both directions when SPLIT=0 |
| wr_sel_i | input | 1 | Decoded window hit for writes (SPLIT=1 only) |
| rd_stb_i | input | 1 | Host read strobe |
| wr_stb_i | input | 1 | Host write strobe |
| wdata_i | input | 8*WORD_BYTES | Host write data |
| sub_rd_sel_o | output | 1 | Read-side select toward the sub-block |
| sub_rd_addr_o | output | OFS_W | Read word offset inside the window |
| sub_wr_sel_o | output | 1 | Write-side select toward the sub-block |
| sub_wr_addr_o | output | OFS_W | Write word offset inside the window |
| sub_wdata_o | output | DW | Write data toward the sub-block |
| sub_rd_stb_o | output | 1 | Gated read strobe |
| sub_wr_stb_o | output | 1 | Gated write strobe |
| sub_rdata_i | input | DW | Read data from the sub-block |
| sub_rd_done_i | input | 1 | Read completion from the sub-block |
| sub_wr_done_i | input | 1 | Write completion from the sub-block |
| sub_rd_err_i | input | 1 | Read error from the sub-block; tie to 0 if unused |
| sub_wr_err_i | input | 1 | Write error from the sub-block; tie to 0 if unused |
| rdata_o | output | 8*WORD_BYTES | Read data back to the host |
| rd_done_o | output | 1 | Read completion back to the host |
| wr_done_o | output | 1 | Write completion back to the host |
| rd_err_o | output | 1 | Read error back to the host |
| wr_err_o | output | 1 | Write error back to the host |

## Verification
The block holds no state, so a wrong internal choice shows at the ports in the same cycle as the stimulus. One example is a direction select taken from the wrong side. Another is a strobe left ungated. A third is an offset slice shifted by a bit. The bench drives a combined address and control sweep on three configurations at once: split read-write with errors and a narrow sub-block, shared read-write without errors, and split read-only. It compares every output against values worked out from the requirements, half a clock after each change. Ignored inputs are toggled across the sweep, so any leak into an output shows up at the first pattern that differs.

// File: rtl/subwin_pkg.sv
package subwin_pkg;

    typedef enum logic [1:0] {
        ACC_RO = 2'd0,
        ACC_WO = 2'd1,
        ACC_RW = 2'd2
    } acc_e;

    // Per-direction control bundle produced by a direction gate
    typedef struct packed {
        logic sel;   // select toward the sub-block
        logic stb;   // gated strobe toward the sub-block
        logic done;  // completion back to the host
        logic err;   // error back to the host
    } dir_ctl_t;

    function automatic bit dir_rd_on(acc_e a);
        return a != ACC_WO;
    endfunction

    function automatic bit dir_wr_on(acc_e a);
        return a != ACC_RO;
    endfunction

    function automatic int unsigned min_u(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic int unsigned log2_u(int unsigned v);
        int unsigned r;
        r = 0;
        while ((32'd1 << r) < v) r++;
        return r;
    endfunction

endpackage

// File: rtl/subwin_addr_slice.sv
module subwin_addr_slice #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LO     = 2,
    parameter int unsigned W      = 6,
    parameter bit          EN     = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [W-1:0]      ofs_out
);
    // Bits below the word and above the window are not forwarded
    logic unused_addr;
    assign unused_addr = ^addr_in;

    generate
        if (EN) begin : g_on
            assign ofs_out = addr_in[LO +: W];
        end else begin : g_off
            assign ofs_out = '0;
        end
    endgenerate
endmodule

// File: rtl/subwin_dir_gate.sv
module subwin_dir_gate
    import subwin_pkg::*;
#(
    parameter bit EN     = 1'b1,
    parameter bit ERR_EN = 1'b1
) (
    input  logic     sel_in,
    input  logic     host_stb,
    input  logic     sub_done,
    input  logic     sub_err,
    output dir_ctl_t ctl
);
    generate
        if (EN) begin : g_on
            assign ctl.sel  = sel_in;
            assign ctl.stb  = sel_in & host_stb;
            assign ctl.done = sel_in & sub_done;
            if (ERR_EN) begin : g_err
                assign ctl.err = sel_in & sub_err;
            end else begin : g_noerr
                logic unused_err;
                assign unused_err = sub_err;
                assign ctl.err    = 1'b0;
            end
        end else begin : g_off
            logic unused_in;
            assign unused_in = ^{sel_in, host_stb, sub_done, sub_err};
            assign ctl       = '0;
        end
    endgenerate
endmodule

// File: rtl/subwin_rd_return.sv
module subwin_rd_return #(
    parameter int unsigned DW = 32,
    parameter int unsigned WW = 32,
    parameter bit          EN = 1'b1
) (
    input  logic          sel_in,
    input  logic [DW-1:0] sub_rdata,
    output logic [WW-1:0] host_rdata
);
    generate
        if (EN) begin : g_on
            assign host_rdata = sel_in ? WW'(sub_rdata) : '0;
        end else begin : g_off
            logic unused_rd;
            assign unused_rd  = ^{sel_in, sub_rdata};
            assign host_rdata = '0;
        end
    endgenerate
endmodule

// File: rtl/subwin_fwd.sv
module subwin_fwd
    import subwin_pkg::*;
#(
    parameter int unsigned HOST_ADDR_W = 16,
    parameter int unsigned WORD_BYTES  = 4,
    parameter int unsigned WIN_BYTES   = 256,
    parameter int unsigned SUB_DATA_W  = 32,
    parameter bit          SPLIT       = 1'b0,
    parameter acc_e        ACC         = ACC_RW,
    parameter bit          ERR_EN      = 1'b1,
    localparam int unsigned WORD_W  = WORD_BYTES * 8,
    localparam int unsigned LSB     = log2_u(WORD_BYTES),
    localparam int unsigned WIN_LSB = log2_u(WIN_BYTES),
    localparam int unsigned OFS_W   = WIN_LSB - LSB,
    localparam int unsigned DW      = min_u(SUB_DATA_W, WORD_W)
) (
    input  logic [HOST_ADDR_W-1:0] rd_addr_i,
    input  logic [HOST_ADDR_W-1:0] wr_addr_i,
    input  logic                   rd_sel_i,
    input  logic                   wr_sel_i,
    input  logic                   rd_stb_i,
    input  logic                   wr_stb_i,
    input  logic [WORD_W-1:0]      wdata_i,
    output logic                   sub_rd_sel_o,
    output logic [OFS_W-1:0]       sub_rd_addr_o,
    output logic                   sub_wr_sel_o,
    output logic [OFS_W-1:0]       sub_wr_addr_o,
    output logic [DW-1:0]          sub_wdata_o,
    output logic                   sub_rd_stb_o,
    output logic                   sub_wr_stb_o,
    input  logic [DW-1:0]          sub_rdata_i,
    input  logic                   sub_rd_done_i,
    input  logic                   sub_wr_done_i,
    input  logic                   sub_rd_err_i,
    input  logic                   sub_wr_err_i,
    output logic [WORD_W-1:0]      rdata_o,
    output logic                   rd_done_o,
    output logic                   wr_done_o,
    output logic                   rd_err_o,
    output logic                   wr_err_o
);
    localparam bit HAS_RD = dir_rd_on(ACC);
    localparam bit HAS_WR = dir_wr_on(ACC);

    // Write-side source: own bus in split mode, read-side bus otherwise
    logic [HOST_ADDR_W-1:0] wr_src_addr;
    logic                   wr_src_sel;

    generate
        if (SPLIT) begin : g_split
            assign wr_src_addr = wr_addr_i;
            assign wr_src_sel  = wr_sel_i;
        end else begin : g_shared
            logic unused_wside;
            assign unused_wside = ^{wr_addr_i, wr_sel_i};
            assign wr_src_addr  = rd_addr_i;
            assign wr_src_sel   = rd_sel_i;
        end
    endgenerate

    subwin_addr_slice #(
        .ADDR_W(HOST_ADDR_W), .LO(LSB), .W(OFS_W), .EN(HAS_RD)
    ) rd_slice_i (
        .addr_in (rd_addr_i),
        .ofs_out (sub_rd_addr_o)
    );

    subwin_addr_slice #(
        .ADDR_W(HOST_ADDR_W), .LO(LSB), .W(OFS_W), .EN(HAS_WR)
    ) wr_slice_i (
        .addr_in (wr_src_addr),
        .ofs_out (sub_wr_addr_o)
    );

    dir_ctl_t rd_ctl, wr_ctl;

    subwin_dir_gate #(.EN(HAS_RD), .ERR_EN(ERR_EN)) rd_gate_i (
        .sel_in   (rd_sel_i),
        .host_stb (rd_stb_i),
        .sub_done (sub_rd_done_i),
        .sub_err  (sub_rd_err_i),
        .ctl      (rd_ctl)
    );

    subwin_dir_gate #(.EN(HAS_WR), .ERR_EN(ERR_EN)) wr_gate_i (
        .sel_in   (wr_src_sel),
        .host_stb (wr_stb_i),
        .sub_done (sub_wr_done_i),
        .sub_err  (sub_wr_err_i),
        .ctl      (wr_ctl)
    );

    subwin_rd_return #(.DW(DW), .WW(WORD_W), .EN(HAS_RD)) rd_ret_i (
        .sel_in     (rd_sel_i),
        .sub_rdata  (sub_rdata_i),
        .host_rdata (rdata_o)
    );

    assign sub_rd_sel_o = rd_ctl.sel;
    assign sub_rd_stb_o = rd_ctl.stb;
    assign rd_done_o    = rd_ctl.done;
    assign rd_err_o     = rd_ctl.err;
    assign sub_wr_sel_o = wr_ctl.sel;
    assign sub_wr_stb_o = wr_ctl.stb;
    assign wr_done_o    = wr_ctl.done;
    assign wr_err_o     = wr_ctl.err;

    // Write data: low DW bits pass straight through when writes exist
    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    generate
        if (HAS_WR) begin : g_wdata
            assign sub_wdata_o = wdata_i[DW-1:0];
        end else begin : g_nowdata
            assign sub_wdata_o = '0;
        end
    endgenerate
endmodule

// File: rtl/subwin_fwd_chk.sv
module subwin_fwd_chk
    import subwin_pkg::*;
#(
    parameter acc_e        ACC    = ACC_RW,
    parameter bit          ERR_EN = 1'b1,
    parameter int unsigned WW     = 32
) (
    input logic          rd_stb_i,
    input logic          wr_stb_i,
    input logic          sub_rd_sel_o,
    input logic          sub_wr_sel_o,
    input logic          sub_rd_stb_o,
    input logic          sub_wr_stb_o,
    input logic          sub_rd_done_i,
    input logic          sub_wr_done_i,
    input logic [WW-1:0] rdata_o,
    input logic          rd_done_o,
    input logic          wr_done_o,
    input logic          rd_err_o,
    input logic          wr_err_o
);
    always_comb begin
        if (sub_rd_stb_o) AST_RD_STB_GATED: assert (rd_stb_i && sub_rd_sel_o); // R2
        if (sub_wr_stb_o) AST_WR_STB_GATED: assert (wr_stb_i && sub_wr_sel_o); // R3
        if (!sub_rd_sel_o) AST_RDATA_IDLE_ZERO: assert (rdata_o == '0); // R6
        if (rd_done_o) AST_RD_DONE_FROM_SUB: assert (sub_rd_done_i && sub_rd_sel_o); // R7
        if (wr_done_o) AST_WR_DONE_FROM_SUB: assert (sub_wr_done_i && sub_wr_sel_o); // R7
        if (!ERR_EN) AST_ERR_SILENT: assert (!rd_err_o && !wr_err_o); // R8
        if (ACC == ACC_RO) AST_RO_NO_WRITE: assert (!sub_wr_stb_o && !wr_done_o); // R9
        if (ACC == ACC_WO) AST_WO_NO_READ: assert (!sub_rd_stb_o && !rd_done_o); // R9
    end
endmodule

bind subwin_fwd subwin_fwd_chk #(
    .ACC(ACC), .ERR_EN(ERR_EN), .WW(WORD_W)
) chk_i (
    .rd_stb_i      (rd_stb_i),
    .wr_stb_i      (wr_stb_i),
    .sub_rd_sel_o  (sub_rd_sel_o),
    .sub_wr_sel_o  (sub_wr_sel_o),
    .sub_rd_stb_o  (sub_rd_stb_o),
    .sub_wr_stb_o  (sub_wr_stb_o),
    .sub_rd_done_i (sub_rd_done_i),
    .sub_wr_done_i (sub_wr_done_i),
    .rdata_o       (rdata_o),
    .rd_done_o     (rd_done_o),
    .wr_done_o     (wr_done_o),
    .rd_err_o      (rd_err_o),
    .wr_err_o      (wr_err_o)
);

// File: tb/subwin_fwd_tb.sv
`timescale 1ns/1ps
module subwin_fwd_tb_top;
    import subwin_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    // Shared stimulus
    logic [15:0] rd_addr, wr_addr;
    logic        rs, ws, rst_b, wst, rdn, wdn, re, we;
    logic [31:0] wd, sr;

    // A: split, read-write, errors on, 16-bit sub-block
    logic        a_rsel, a_wsel, a_rstb, a_wstb, a_rdn, a_wdn, a_re, a_we;
    logic [5:0]  a_raddr, a_waddr;
    logic [15:0] a_wdat;
    logic [31:0] a_rdat;
    // B: shared, read-write, errors off, 32-bit
    logic        b_rsel, b_wsel, b_rstb, b_wstb, b_rdn, b_wdn, b_re, b_we;
    logic [5:0]  b_raddr, b_waddr;
    logic [31:0] b_wdat, b_rdat;
    // C: split, read-only, errors on, 32-bit
    logic        c_rsel, c_wsel, c_rstb, c_wstb, c_rdn, c_wdn, c_re, c_we;
    logic [5:0]  c_raddr, c_waddr;
    logic [31:0] c_wdat, c_rdat;

    subwin_fwd #(.SPLIT(1'b1), .ACC(ACC_RW), .ERR_EN(1'b1), .SUB_DATA_W(16)) dut_i (
        .rd_addr_i(rd_addr), .wr_addr_i(wr_addr), .rd_sel_i(rs), .wr_sel_i(ws),
        .rd_stb_i(rst_b), .wr_stb_i(wst), .wdata_i(wd),
        .sub_rd_sel_o(a_rsel), .sub_rd_addr_o(a_raddr), .sub_wr_sel_o(a_wsel),
        .sub_wr_addr_o(a_waddr), .sub_wdata_o(a_wdat), .sub_rd_stb_o(a_rstb),
        .sub_wr_stb_o(a_wstb), .sub_rdata_i(sr[15:0]), .sub_rd_done_i(rdn),
        .sub_wr_done_i(wdn), .sub_rd_err_i(re), .sub_wr_err_i(we),
        .rdata_o(a_rdat), .rd_done_o(a_rdn), .wr_done_o(a_wdn),
        .rd_err_o(a_re), .wr_err_o(a_we));

    subwin_fwd #(.SPLIT(1'b0), .ACC(ACC_RW), .ERR_EN(1'b0), .SUB_DATA_W(32)) dut_sh_i (
        .rd_addr_i(rd_addr), .wr_addr_i(wr_addr), .rd_sel_i(rs), .wr_sel_i(ws),
        .rd_stb_i(rst_b), .wr_stb_i(wst), .wdata_i(wd),
        .sub_rd_sel_o(b_rsel), .sub_rd_addr_o(b_raddr), .sub_wr_sel_o(b_wsel),
        .sub_wr_addr_o(b_waddr), .sub_wdata_o(b_wdat), .sub_rd_stb_o(b_rstb),
        .sub_wr_stb_o(b_wstb), .sub_rdata_i(sr), .sub_rd_done_i(rdn),
        .sub_wr_done_i(wdn), .sub_rd_err_i(re), .sub_wr_err_i(we),
        .rdata_o(b_rdat), .rd_done_o(b_rdn), .wr_done_o(b_wdn),
        .rd_err_o(b_re), .wr_err_o(b_we));

    subwin_fwd #(.SPLIT(1'b1), .ACC(ACC_RO), .ERR_EN(1'b1), .SUB_DATA_W(32)) dut_ro_i (
        .rd_addr_i(rd_addr), .wr_addr_i(wr_addr), .rd_sel_i(rs), .wr_sel_i(ws),
        .rd_stb_i(rst_b), .wr_stb_i(wst), .wdata_i(wd),
        .sub_rd_sel_o(c_rsel), .sub_rd_addr_o(c_raddr), .sub_wr_sel_o(c_wsel),
        .sub_wr_addr_o(c_waddr), .sub_wdata_o(c_wdat), .sub_rd_stb_o(c_rstb),
        .sub_wr_stb_o(c_wstb), .sub_rdata_i(sr), .sub_rd_done_i(rdn),
        .sub_wr_done_i(wdn), .sub_rd_err_i(re), .sub_wr_err_i(we),
        .rdata_o(c_rdat), .rd_done_o(c_rdn), .wr_done_o(c_wdn),
        .rd_err_o(c_re), .wr_err_o(c_we));

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        logic [5:0] ro, wo;
        ro = rd_addr[7:2];
        wo = wr_addr[7:2];
        // Config A (split RW, err, 16-bit)
        chk("R1", "A raddr", 32'(a_raddr), 32'(ro));
        chk("R5", "A waddr", 32'(a_waddr), 32'(wo));
        chk("R5", "A wsel", 32'(a_wsel), 32'(ws));
        chk("R2", "A rstb", 32'(a_rstb), 32'(rs & rst_b));
        chk("R3", "A wstb", 32'(a_wstb), 32'(ws & wst));
        chk("R4", "A wdata", 32'(a_wdat), 32'(wd[15:0]));
        chk("R6", "A rdata", a_rdat, rs ? {16'h0, sr[15:0]} : 32'h0);
        chk("R7", "A rdone", 32'(a_rdn), 32'(rs & rdn));
        chk("R7", "A wdone", 32'(a_wdn), 32'(ws & wdn));
        chk("R8", "A rerr", 32'(a_re), 32'(rs & re));
        chk("R8", "A werr", 32'(a_we), 32'(ws & we));
        // Config B (shared RW, no err)
        chk("R5", "B wsel", 32'(b_wsel), 32'(rs));
        chk("R5", "B waddr", 32'(b_waddr), 32'(ro));
        chk("R1", "B raddr", 32'(b_raddr), 32'(ro));
        chk("R3", "B wstb", 32'(b_wstb), 32'(rs & wst));
        chk("R4", "B wdata", b_wdat, wd);
        chk("R6", "B rdata", b_rdat, rs ? sr : 32'h0);
        chk("R7", "B wdone", 32'(b_wdn), 32'(rs & wdn));
        chk("R8", "B errs", 32'({b_re, b_we}), 32'h0);
        // Config C (split RO, err)
        chk("R2", "C rstb", 32'(c_rstb), 32'(rs & rst_b));
        chk("R6", "C rdata", c_rdat, rs ? sr : 32'h0);
        chk("R8", "C rerr", 32'(c_re), 32'(rs & re));
        chk("R9", "C wside", {c_wdat[25:0], c_waddr}, 32'h0);
        chk("R9", "C wctl", 32'({c_wsel, c_wstb, c_wdn, c_we}), 32'h0);
        chk("R9", "C wdata hi", 32'(c_wdat[31:26]), 32'h0);
    endtask

    initial begin
        rd_addr = '0; wr_addr = '0; wd = '0; sr = '0;
        {rs, ws, rst_b, wst, rdn, wdn, re, we} = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R10: idle inputs give quiet control outputs
        @(negedge clk);
        chk("R10", "idle A", 32'({a_rsel, a_wsel, a_rstb, a_wstb, a_rdn, a_wdn, a_re, a_we}), 32'h0);
        chk("R10", "idle B", 32'({b_rsel, b_wsel, b_rstb, b_wstb, b_rdn, b_wdn, b_re, b_we}), 32'h0);
        chk("R10", "idle C", 32'({c_rsel, c_wsel, c_rstb, c_wstb, c_rdn, c_wdn, c_re, c_we}), 32'h0);
        // Sweep: 64 address patterns x 256 control combinations
        for (int i = 0; i < 64; i++) begin
            for (int c = 0; c < 256; c++) begin
                @(posedge clk);
                rd_addr = {8'(i * 29 + c), 6'(i), 2'(c)};
                wr_addr = {8'(c * 7), 6'(63 - i), 2'(i)};
                {rs, ws, rst_b, wst, rdn, wdn, re, we} = 8'(c);
                wd = 32'h9E37_79B9 * 32'(i * 256 + c + 1);
                sr = 32'h85EB_CA6B ^ (32'(c) << 16) ^ 32'(i * 1103);
                @(negedge clk);
                check_all();
            end
        end
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule